// File: doc/BRIEF.md
# Array Reduce-Sum Sequencer

This block adds up every byte held in a small memory array. It has a read port of its own on a RAM with two read ports; the other read port belongs to a display path and is not part of this block. A single-cycle start pulse, for example from a debounced button, starts a pass. The block walks a read address across the whole array. It adds each returned byte into an accumulator wide enough that no total can overflow. At the end it copies the total into a result register that drives LEDs.

The RAM is taken to be synchronous: data appears one clock after its address. Each element therefore takes two cycles, a present cycle and an add cycle. The published total stays fixed between passes, even when the memory is rewritten. It changes only when a new pass ends. A start pulse that arrives while a pass is running is ignored.

Top module: `reduce_sum_seq`

## Requirements
- R1: After reset, `sum_o` is 0, `busy_o` is 0, `done_o` is 0 and `rd_addr_o` is 0.
- R2: When `start_i` is 1 at a clock edge while `busy_o` is 0, `busy_o` goes to 1 in the following cycle and stays at 1 for exactly 2*DEPTH+1 cycles (33 with the defaults).
- R3: During a pass, in busy cycle k (counting from 0), `rd_addr_o` equals k/2 for k below 2*DEPTH. The address therefore steps 0,0,1,1,...,15,15.
- R4: The byte returned on `rd_data_i` one cycle after each address is presented is added to the total. The total is exact in 12 bits: an array of all 0xFF gives 0xFF0.
- R5: `done_o` is a one-cycle pulse in the cycle directly after `busy_o` falls. `sum_o` shows the new total in that same cycle.
- R6: A `start_i` pulse while `busy_o` is 1 has no effect: the pass keeps its timing and its total.
- R7: `sum_o` changes only in a cycle where `done_o` is 1. Memory writes between passes leave it unchanged.
- R8: While `busy_o` is 0, `rd_addr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle request to start a pass |
| rd_addr_o | output | 4 | Address to the dedicated RAM read port |
| rd_data_i | input | 8 | Byte returned by the RAM, one cycle after its address |
| busy_o | output | 1 | A pass is running |
| done_o | output | 1 | One-cycle pulse when a new total is published |
| sum_o | output | 12 | Published total, held until the next pass completes |

## Verification
After the edge that samples `start_i`, `busy_o` rises one cycle later. Address k/2 appears in busy cycle k. The byte fetched for that address is counted at the edge that ends the next cycle. `done_o` and the new `sum_o` appear 34 cycles after the start edge. The bench keeps a behavioural phase counter and a running total that advance on each rising edge. It compares every output against them at the falling edge of every cycle, so each result is checked in exactly the cycle it is due. This also covers the cycles where nothing should change.

// File: rtl/reduce_sum_pkg.sv
package reduce_sum_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_ACCUM = 2'd2,
    ST_DONE  = 2'd3
  } rs_state_e;
endpackage

// File: rtl/rs_addr_cnt.sv
module rs_addr_cnt #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LastAddr = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (clr_i)   addr_q <= '0;
    else if (inc_i)   addr_q <= (addr_q == LastAddr) ? '0 : addr_q + AW'(1);
  end

  assign addr_o = addr_q;
  assign last_o = (addr_q == LastAddr);
endmodule

// File: rtl/rs_accum.sv
module rs_accum #(
  parameter int DW = 8,
  parameter int SW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          add_i,
  input  logic [DW-1:0] data_i,
  input  logic          publish_i,
  output logic [SW-1:0] sum_o
);
  logic [SW-1:0] acc_q, res_q;
  logic [SW-1:0] data_ext;

  generate
    if (SW > DW) begin : g_ext
      assign data_ext = {{(SW-DW){1'b0}}, data_i};
    end else begin : g_trunc
      assign data_ext = data_i[SW-1:0];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clr_i)   acc_q <= '0;
    else if (add_i)   acc_q <= acc_q + data_ext;
  end

  // result frozen except on publish
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        res_q <= '0;
    else if (publish_i) res_q <= acc_q;
  end

  assign sum_o = res_q;
endmodule

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import reduce_sum_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  output logic addr_clr_o,
  output logic addr_inc_o,
  output logic acc_clr_o,
  output logic acc_add_o,
  output logic publish_o,
  output logic busy_o,
  output logic done_o
);
  rs_state_e state_q, state_d;
  logic      done_q;

  always_comb begin
    state_d    = state_q;
    addr_clr_o = 1'b0;
    addr_inc_o = 1'b0;
    acc_clr_o  = 1'b0;
    acc_add_o  = 1'b0;
    publish_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        addr_clr_o = 1'b1;
        if (start_i) begin
          acc_clr_o = 1'b1;
          state_d   = ST_READ;
        end
      end
      ST_READ:  state_d = ST_ACCUM;
      ST_ACCUM: begin
        acc_add_o  = 1'b1;
        addr_inc_o = 1'b1;
        state_d    = last_i ? ST_DONE : ST_READ;
      end
      ST_DONE: begin
        publish_o = 1'b1;
        state_d   = ST_IDLE;
      end
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= publish_o;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/reduce_sum_seq.sv
module reduce_sum_seq #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int SW   = DW + AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [SW-1:0] sum_o
);
  logic addr_clr, addr_inc, acc_clr, acc_add, publish, last;

  rs_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .last_i     (last),
    .addr_clr_o (addr_clr),
    .addr_inc_o (addr_inc),
    .acc_clr_o  (acc_clr),
    .acc_add_o  (acc_add),
    .publish_o  (publish),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  rs_addr_cnt #(.DEPTH(DEPTH)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (addr_clr),
    .inc_i  (addr_inc),
    .addr_o (rd_addr_o),
    .last_o (last)
  );

  rs_accum #(.DW(DW), .SW(SW)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (acc_clr),
    .add_i     (acc_add),
    .data_i    (rd_data_i),
    .publish_i (publish),
    .sum_o     (sum_o)
  );
endmodule

// File: rtl/reduce_sum_seq_chk.sv
module reduce_sum_seq_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int SW    = 12,
  parameter int DW    = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] rd_addr_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [SW-1:0] sum_o
);
  localparam int PassLen = 2 * DEPTH + 1;
  localparam int CW      = $clog2(PassLen + 1) + 1;
  localparam logic [SW-1:0] MaxSum = SW'(DEPTH * ((1 << DW) - 1));

  logic [CW-1:0] busy_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt <= '0;
    else if (busy_o) busy_cnt <= busy_cnt + CW'(1);
    else             busy_cnt <= '0;
  end

  a_r1_reset_idle: assert property (@(posedge clk_i) !rst_ni |=> (!busy_o && !done_o));
  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r2_pass_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_cnt == CW'(PassLen)));
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
  a_r7_sum_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(sum_o));
  a_r8_idle_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_addr_o == '0));
  always_comb begin
    if (rst_ni) a_r4_no_overflow: assert (sum_o <= MaxSum);
  end
endmodule

bind reduce_sum_seq reduce_sum_seq_chk #(
  .DEPTH(DEPTH), .AW(AW), .SW(SW), .DW(DW)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .rd_addr_o (rd_addr_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .sum_o     (sum_o)
);

// File: tb/reduce_sum_seq_tb_top.sv
`timescale 1ns/1ps
module reduce_sum_seq_tb_top;
  localparam int DEPTH = 16;
  localparam int DW    = 8;
  localparam int AW    = 4;
  localparam int SW    = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] rd_addr_o;
  logic [DW-1:0] rd_data_i;
  logic          busy_o, done_o;
  logic [SW-1:0] sum_o;

  logic [DW-1:0] mem [DEPTH];

  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  reduce_sum_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .sum_o(sum_o)
  );

  // behavioural synchronous RAM read port
  always @(posedge clk) rd_data_i <= mem[rd_addr_o];

  // reference model: phase -1 idle, 0..2*DEPTH-1 walking, 2*DEPTH final
  int phase = -1;
  int acc_m = 0, sum_m = 0;
  bit done_m = 0;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase = -1; acc_m = 0; sum_m = 0; done_m = 0;
    end else begin
      if (phase >= 0 && phase < 2*DEPTH && phase % 2 == 0)
        acc_m = acc_m + int'(mem[phase/2]);
      done_m = 0;
      if (phase == -1) begin
        if (start_i) begin phase = 0; acc_m = 0; end
      end else if (phase == 2*DEPTH) begin
        sum_m = acc_m; done_m = 1; phase = -1;
      end else phase = phase + 1;
    end
  end

  task automatic cmp(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      cmp("R2/R6", "busy_o", int'(busy_o), (phase != -1) ? 1 : 0);
      cmp("R5", "done_o", int'(done_o), int'(done_m));
      cmp("R4/R7", "sum_o", int'(sum_o), sum_m);
      cmp("R3/R8", "rd_addr_o", int'(rd_addr_o),
          (phase >= 0 && phase < 2*DEPTH) ? phase/2 : 0);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    cmp("R1", "sum_o", int'(sum_o), 0);
    cmp("R1", "busy_o", int'(busy_o), 0);
    cmp("R1", "done_o", int'(done_o), 0);
    cmp("R1", "rd_addr_o", int'(rd_addr_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    // R4: example array, total 0x5B
    mem[0] = 8'h0A; mem[1] = 8'h51;
    pulse_start(); wait_idle();
    cmp("R4", "example total", int'(sum_o), 'h5B);

    // R7: write while idle, result frozen
    mem[15] = 8'hFF;
    repeat (20) @(negedge clk);
    cmp("R7", "sum after write", int'(sum_o), 'h5B);

    // R6: extra starts during a pass
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'(i * 7 + 3);
    pulse_start();
    repeat (5) @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk); start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    wait_idle();
    cmp("R6", "ramp total", int'(sum_o), 888);

    // R4: all 0xFF, no overflow
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
    pulse_start(); wait_idle();
    cmp("R4", "full total", int'(sum_o), 'hFF0);

    // all zero, then back-to-back starts held high
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    @(negedge clk); start_i = 1'b1;
    repeat (40) @(negedge clk); start_i = 1'b0;
    wait_idle();
    cmp("R4", "zero total", int'(sum_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule